// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Compare Output

This block is an up-counter that advances once for every cycle in which an external prescaler raises its clock-enable input. A two-bit wave-mode field picks how the count sequence ends: in free-running mode the counter runs through its full range and rolls from all-ones back to zero; in clear-on-match mode it returns to zero right after it equals the compare value. The compare value therefore sets the period in that mode.

A compare unit looks at the counter on every enabled cycle and drives a single waveform pin. A two-bit pin-action field picks what a match does to the pin: nothing, toggle, clear or set. Changing that field never moves the pin by itself; the new action first shows at the next match. Software can also fire a force strobe, which applies the configured action at once without a match. Two sticky flags, each with its own clear input, record overflows and compare matches. All state is written through one small register write port.

Top module: `wave_timer8`

## Requirements
- R1: After reset the counter, the compare value, both mode fields, the pin and both flags are zero.
- R2: The counter changes only on a cycle where `tick` is high or the counter is written; otherwise it holds its value.
- R3: In free-running mode (wave-mode 0) the counter rolls from all-ones to zero and counts straight past the compare value without clearing.
- R4: The overflow flag is set at the clock edge where an enabled count moves the counter from all-ones to zero, stays set until `ovf_clr` is asserted, and a new overflow in the same cycle as `ovf_clr` leaves it set.
- R5: In clear-on-match mode (wave-mode 2) an enabled cycle with the counter equal to the compare value loads zero into the counter and sets the compare flag at that edge; reaching zero this way does not set the overflow flag.
- R6: The compare flag is set on every compare match in any wave mode, stays set until `cmp_clr` is asserted, and a match in the same cycle as `cmp_clr` leaves it set.
- R7: On a match the pin follows the pin-action field (control bits [3:2]): 00 leaves it alone, 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R8: A write to the control register never changes the pin in that cycle; the newly written action is applied first at the next match or force.
- R9: In wave-modes 0 and 2, `force_cmp` applies the pin action at the next edge even without `tick`; it neither sets the compare flag nor changes the counter, and a force together with a match applies the action only once.
- R10: Wave-modes 1 and 3 count exactly like free-running mode and matches still act on the pin, but `force_cmp` is ignored in them.
- R11: A counter write (select 0) in the same cycle as `tick` loads the written value instead of incrementing, and that cycle produces no compare match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare value, 2 control (bits [1:0] wave mode, [3:2] pin action) |
| wr_data | input | CNT_W | Write data |
| force_cmp | input | 1 | Force-compare strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| cmp_clr | input | 1 | Clears the compare flag |
| count_q | output | CNT_W | Current counter value |
| cmp_pin | output | 1 | Waveform pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench drives the counter through the roll-over from all-ones and checks that the overflow flag rises in exactly the edge where the count becomes zero; a design that raised it one cycle early or late, or also on a clear-on-match return to zero, is caught there. It rewrites the pin action between matches to catch a design that moves the pin on the write itself, and fires force alongside a match to catch a double toggle, a spurious compare flag or a counter cleared by force. It also writes the counter in an enabled cycle whose count equals the compare value, which exposes a design that lets the increment win or reports a match from the overwritten value.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'd0,
    WM_RSV1   = 2'd1,
    WM_CTC    = 2'd2,
    WM_RSV3   = 2'd3
  } wave_mode_e;

  typedef enum logic [1:0] {
    PA_NONE   = 2'd0,
    PA_TOGGLE = 2'd1,
    PA_CLEAR  = 2'd2,
    PA_SET    = 2'd3
  } pin_act_e;

  typedef enum logic [1:0] {
    RS_COUNT = 2'd0,
    RS_TOP   = 2'd1,
    RS_CTRL  = 2'd2,
    RS_NONE  = 2'd3
  } reg_sel_e;

  // Pin level after one action event.
  function automatic logic apply_act(pin_act_e act, logic cur);
    case (act)
      PA_TOGGLE: return ~cur;
      PA_CLEAR:  return 1'b0;
      PA_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

  // Force only acts in the non-PWM wave modes.
  function automatic logic force_allowed(wave_mode_e m);
    return (m == WM_NORMAL) || (m == WM_CTC);
  endfunction

endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] top_q,
  output wave_mode_e       mode_q,
  output pin_act_e         act_q,
  output logic             cnt_wr
);

  logic top_wr;
  logic ctrl_wr;

  assign cnt_wr  = wr_en && (reg_sel_e'(wr_sel) == RS_COUNT);
  assign top_wr  = wr_en && (reg_sel_e'(wr_sel) == RS_TOP);
  assign ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == RS_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q  <= '0;
      mode_q <= WM_NORMAL;
      act_q  <= PA_NONE;
    end else begin
      if (top_wr) top_q <= wr_data;
      if (ctrl_wr) begin
        mode_q <= wave_mode_e'(wr_data[1:0]);
        act_q  <= pin_act_e'(wr_data[3:2]);
      end
    end
  end

endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] top,
  input  wave_mode_e       mode,
  output logic [CNT_W-1:0] count,
  output logic             match_ev,
  output logic             ovf_ev
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Successor of the counter for one enabled cycle.
  function automatic logic [CNT_W-1:0] next_count(
    logic [CNT_W-1:0] cur, logic [CNT_W-1:0] lim, logic clr_on_match);
    if (clr_on_match && (cur == lim)) return '0;
    return cur + 1'b1;
  endfunction

  logic step;
  assign step     = tick && !cnt_wr;
  assign match_ev = step && (count == top);
  assign ovf_ev   = step && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (cnt_wr) count <= cnt_wdata;
    else if (tick)   count <= next_count(count, top, mode == WM_CTC);
  end

endmodule

// File: rtl/wt_outcmp.sv
module wt_outcmp
  import wt_pkg::*;
#(
  parameter int N_FLAGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_ev,
  input  logic       ovf_ev,
  input  logic       force_cmp,
  input  wave_mode_e mode,
  input  pin_act_e   act,
  input  logic       ovf_clr,
  input  logic       cmp_clr,
  output logic       pin,
  output logic       ovf_flag,
  output logic       cmp_flag
);

  logic act_ev;
  logic [N_FLAGS-1:0] set_v;
  logic [N_FLAGS-1:0] clr_v;
  logic [N_FLAGS-1:0] flag_q;

  assign act_ev = match_ev || (force_cmp && force_allowed(mode));

  always_ff @(posedge clk) begin
    if (!rst_n)      pin <= 1'b0;
    else if (act_ev) pin <= apply_act(act, pin);
  end

  assign set_v = {match_ev, ovf_ev};
  assign clr_v = {cmp_clr, ovf_clr};

  // Sticky flags: a hardware set beats a clear in the same cycle.
  for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_q[gi] <= 1'b0;
      else if (set_v[gi]) flag_q[gi] <= 1'b1;
      else if (clr_v[gi]) flag_q[gi] <= 1'b0;
    end
  end

  assign ovf_flag = flag_q[0];
  assign cmp_flag = flag_q[1];

endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             force_cmp,
  input  logic             ovf_clr,
  input  logic             cmp_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             cmp_pin,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  logic [CNT_W-1:0] top_q;
  wave_mode_e       mode_q;
  pin_act_e         act_q;
  logic             cnt_wr;
  logic             match_ev;
  logic             ovf_ev;

  wt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .top_q   (top_q),
    .mode_q  (mode_q),
    .act_q   (act_q),
    .cnt_wr  (cnt_wr)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (wr_data),
    .top       (top_q),
    .mode      (mode_q),
    .count     (count_q),
    .match_ev  (match_ev),
    .ovf_ev    (ovf_ev)
  );

  wt_outcmp #(.N_FLAGS(2)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_ev  (match_ev),
    .ovf_ev    (ovf_ev),
    .force_cmp (force_cmp),
    .mode      (mode_q),
    .act       (act_q),
    .ovf_clr   (ovf_clr),
    .cmp_clr   (cmp_clr),
    .pin       (cmp_pin),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag)
  );

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             force_cmp,
  input logic [CNT_W-1:0] count_q,
  input logic             cmp_pin,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             match_ev,
  input logic             ovf_ev,
  input logic [1:0]       mode_q
);

  logic port_cnt_wr;
  assign port_cnt_wr = wr_en && (wr_sel == 2'd0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !port_cnt_wr) |=> $stable(count_q));

  a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (ovf_flag && (count_q == '0)));

  a_r5_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && (mode_q == 2'd2)) |=> (count_q == '0));

  a_r6_cmp_sets: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> cmp_flag);

  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_ev && !force_cmp) |=> $stable(cmp_pin));

  a_r9_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !match_ev && !cmp_flag) |=> !cmp_flag);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    port_cnt_wr |=> (count_q == $past(wr_data)));

  a_r11_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    port_cnt_wr |-> !match_ev);

endmodule

bind wave_timer8 wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .force_cmp (force_cmp),
  .count_q   (count_q),
  .cmp_pin   (cmp_pin),
  .ovf_flag  (ovf_flag),
  .cmp_flag  (cmp_flag),
  .match_ev  (match_ev),
  .ovf_ev    (ovf_ev),
  .mode_q    (mode_q)
);

// File: tb/sim_wave_timer8.sv
module sim_wave_timer8;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd3;
  logic [CNT_W-1:0] wr_data = '0;
  logic             force_cmp = 1'b0;
  logic             ovf_clr = 1'b0;
  logic             cmp_clr = 1'b0;
  logic [CNT_W-1:0] count_q;
  logic             cmp_pin;
  logic             ovf_flag;
  logic             cmp_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  wave_timer8 #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .force_cmp(force_cmp), .ovf_clr(ovf_clr),
    .cmp_clr(cmp_clr), .count_q(count_q), .cmp_pin(cmp_pin),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Control word: wave mode in bits [1:0], pin action in bits [3:2].
  function automatic logic [CNT_W-1:0] ctrl(int wm, int pa);
    return CNT_W'((pa << 2) | wm);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock edge; inputs change and outputs are sampled 1 time unit later.
  task automatic cyc();
    @(posedge clk);
    #1;
    wr_en = 1'b0; force_cmp = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
  endtask

  task automatic wreg(int sel, int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = CNT_W'(data);
    cyc();
  endtask

  task automatic clr_flags();
    ovf_clr = 1'b1; cmp_clr = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count_q), 0);
    chk("R1 pin", int'(cmp_pin), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 cmp", int'(cmp_flag), 0);
  endtask

  task automatic t_free_run();
    wreg(1, 8'h10); wreg(2, ctrl(0, 0)); wreg(0, 8'hFD); clr_flags();
    cyc();
    chk("R2 hold without tick", int'(count_q), 8'hFD);
    tick = 1'b1;
    cyc(); cyc();
    chk("R3 count at max", int'(count_q), 8'hFF);
    chk("R4 ovf not early", int'(ovf_flag), 0);
    cyc();
    chk("R3 wrap to zero", int'(count_q), 0);
    chk("R4 ovf at zero", int'(ovf_flag), 1);
    tick = 1'b0;
    cyc(); cyc();
    chk("R4 ovf sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1; cyc();
    chk("R4 ovf cleared", int'(ovf_flag), 0);
    wreg(0, 8'hFF);
    tick = 1'b1; ovf_clr = 1'b1; cyc(); tick = 1'b0;
    chk("R4 set beats clear", int'(ovf_flag), 1);
    wreg(0, 8'h0F); clr_flags();
    tick = 1'b1; cyc(); cyc(); tick = 1'b0;
    chk("R3 passes compare value", int'(count_q), 8'h11);
    chk("R6 match in free-run", int'(cmp_flag), 1);
  endtask

  task automatic t_ctc();
    wreg(1, 3); wreg(2, ctrl(2, 0)); wreg(0, 0); clr_flags();
    tick = 1'b1;
    cyc(); cyc(); cyc();
    chk("R5 reaches top", int'(count_q), 3);
    chk("R5 no flag before match", int'(cmp_flag), 0);
    cyc();
    chk("R5 clears at top", int'(count_q), 0);
    chk("R5 cmp flag", int'(cmp_flag), 1);
    chk("R5 no ovf", int'(ovf_flag), 0);
    cmp_clr = 1'b1; cyc();
    chk("R6 cmp cleared", int'(cmp_flag), 0);
    cyc(); cyc();
    cmp_clr = 1'b1; cyc();
    chk("R6 set beats clear", int'(cmp_flag), 1);
    tick = 1'b0;
  endtask

  task automatic t_actions();
    wreg(1, 1); wreg(0, 0); wreg(2, ctrl(2, 1));
    tick = 1'b1;
    cyc(); cyc();
    chk("R7 toggle 1", int'(cmp_pin), 1);
    cyc(); cyc();
    chk("R7 toggle 2", int'(cmp_pin), 0);
    tick = 1'b0;
    wreg(2, ctrl(2, 3));
    chk("R8 write set no pin change", int'(cmp_pin), 0);
    tick = 1'b1; cyc();
    chk("R8 no change before match", int'(cmp_pin), 0);
    cyc();
    chk("R7 set", int'(cmp_pin), 1);
    tick = 1'b0;
    wreg(2, ctrl(2, 2));
    chk("R8 write clear no pin change", int'(cmp_pin), 1);
    tick = 1'b1; cyc(); cyc();
    chk("R7 clear", int'(cmp_pin), 0);
    tick = 1'b0;
    wreg(2, ctrl(2, 3));
    tick = 1'b1; cyc(); cyc(); tick = 1'b0;
    wreg(2, ctrl(2, 0));
    tick = 1'b1; cyc(); cyc(); tick = 1'b0;
    chk("R7 none keeps pin", int'(cmp_pin), 1);
  endtask

  task automatic t_force();
    wreg(2, ctrl(0, 1)); wreg(1, 8'h40); wreg(0, 8'h10); clr_flags();
    force_cmp = 1'b1; cyc();
    chk("R9 force toggles", int'(cmp_pin), 0);
    chk("R9 force no flag", int'(cmp_flag), 0);
    chk("R9 force no count", int'(count_q), 8'h10);
    wreg(2, ctrl(2, 1)); wreg(1, 5); wreg(0, 5);
    force_cmp = 1'b1; cyc();
    chk("R9 force in CTC", int'(cmp_pin), 1);
    chk("R9 force keeps count", int'(count_q), 5);
    tick = 1'b1; force_cmp = 1'b1; cyc(); tick = 1'b0;
    chk("R9 force+match once", int'(cmp_pin), 0);
    chk("R9 match clears", int'(count_q), 0);
    chk("R9 match flag", int'(cmp_flag), 1);
  endtask

  task automatic t_reserved();
    wreg(2, ctrl(1, 1)); wreg(1, 2); wreg(0, 1);
    force_cmp = 1'b1; cyc();
    chk("R10 force ignored", int'(cmp_pin), 0);
    tick = 1'b1; cyc(); cyc(); tick = 1'b0;
    chk("R10 no clear at top", int'(count_q), 3);
    chk("R10 match acts", int'(cmp_pin), 1);
  endtask

  task automatic t_write_prio();
    wreg(2, ctrl(0, 1)); wreg(1, 5); wreg(0, 5); clr_flags();
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h09; cyc();
    tick = 1'b0;
    chk("R11 write beats tick", int'(count_q), 9);
    chk("R11 no match flag", int'(cmp_flag), 0);
    chk("R11 no pin action", int'(cmp_pin), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_free_run();
    t_ctc();
    t_actions();
    t_force();
    t_reserved();
    t_write_prio();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule